// File: doc/BRIEF.md
# Shared GPIO Port with Peripheral Override

This block is a parallel I/O port of parameterised width. Each bit has a direction flag, an output latch and a pin-read path. Software reaches these through a small single-cycle register bus. The bus has one address for the direction flags, one for the latch and one for the pin levels.

Any bit can also be taken over by an on-chip peripheral. The peripheral supplies an enable, an output-enable and an output value for that bit. A per-bit multiplexer gives the pad to the peripheral only while it is enabled and actively driving. At all other times the port keeps control. The pad is modelled as separate input, output and output-enable signals. The synchronised pad input goes back to both the port read path and the peripheral. The peripheral input is blanked while the port itself drives that pad, so the port's own output never loops into the peripheral.

A mask parameter marks which bits exist. Missing bits read as zero, never drive the pad and ignore writes.

Top module: `gpio_shared_port`

## Requirements
- R1: After a synchronous reset every implemented direction flag is 1 (input), the latch is all zeros, pad_oe is all zeros and bus_rdata is zero.
- R2: A write to address 0 sets the direction flags. A flag of 1 turns the pad driver off and a flag of 0 turns it on, unless the peripheral owns the bit.
- R3: A write to address 1 loads the latch. While the port owns a bit, pad_out equals that bit's latch value.
- R4: A write to address 2 also loads the latch, and changes no direction flag. A read of address 2 returns pad_in as sampled by a two-stage synchroniser.
- R5: When periph_en and periph_oe are both 1 for an implemented bit, pad_oe is 1 and pad_out equals periph_out for that bit, whatever the port registers hold.
- R6: When periph_en is 1 but periph_oe is 0, or when periph_en is 0, the port's direction flag and latch control the pad.
- R7: periph_in carries the synchronised pad level, except that it is 0 for any bit the port is driving itself (port owns the bit and its direction flag is 0).
- R8: Bits that are clear in IMPL_MASK read as 0 at every address. For those bits pad_oe, pad_out and periph_in are 0, and writes to them have no effect.
- R9: bus_rdata shows the addressed register on the clock edge after the address is presented. Address 3 reads as zero, and a write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 latch, 2 pin |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| periph_en | input | WIDTH | Peripheral enable, one per bit |
| periph_oe | input | WIDTH | Peripheral drive request, one per bit |
| periph_out | input | WIDTH | Peripheral output value, one per bit |
| periph_in | output | WIDTH | Synchronised pad value to the peripheral |
| pad_in | input | WIDTH | Pad input level |
| pad_out | output | WIDTH | Pad output value |
| pad_oe | output | WIDTH | Pad output enable |

## Verification
The hardest case to reach is a bit where the port drives the pad while the pad input shows a different level. Only then does blanking periph_in differ from passing the pad level straight through. A second hard case is a peripheral that is enabled but not driving, sitting next to one that drives. The stimulus sets direction flags to 0 through bus writes, then draws pad_in, periph_en and periph_oe freshly every cycle. This mixes ownership states across the bits. Directed steps also force an enabled peripheral with no drive onto a port-driven bit, and write to bits that are missing from the mask.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wen,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] bus_rdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lat_q
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] rd_next;

  assign sel = reg_sel_e'(bus_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      lat_q <= '0;
    end else if (bus_wen) begin
      unique case (sel)
        SEL_DIR:          dir_q <= bus_wdata | ~IMPL_MASK;
        SEL_LAT, SEL_PIN: lat_q <= bus_wdata & IMPL_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DIR: rd_next = dir_q & IMPL_MASK;
      SEL_LAT: rd_next = lat_q & IMPL_MASK;
      SEL_PIN: rd_next = pin_sync & IMPL_MASK;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_bit_mux.sv
module gpio_bit_mux #(
  parameter bit IMPL = 1'b1
) (
  input  logic dir,
  input  logic lat,
  input  logic p_en,
  input  logic p_oe,
  input  logic p_out,
  input  logic pin_sync,
  output logic pad_out,
  output logic pad_oe,
  output logic p_in
);
  generate
    if (IMPL) begin : g_live
      logic periph_owns;
      logic port_drives;
      assign periph_owns = p_en & p_oe;
      assign port_drives = ~periph_owns & ~dir;
      assign pad_out     = periph_owns ? p_out : lat;
      assign pad_oe      = periph_owns | port_drives;
      assign p_in        = pin_sync & ~port_drives;
    end else begin : g_dead
      assign pad_out = 1'b0;
      assign pad_oe  = 1'b0;
      assign p_in    = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = 8'hBF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wen,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] periph_en,
  input  logic [WIDTH-1:0] periph_oe,
  input  logic [WIDTH-1:0] periph_out,
  output logic [WIDTH-1:0] periph_in,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  localparam int SYNC_STAGES = 2;

  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_w;
  logic [WIDTH-1:0] lat_w;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .pin_sync(pin_sync), .bus_rdata(bus_rdata),
    .dir_q(dir_w), .lat_q(lat_w)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    gpio_bit_mux #(.IMPL(IMPL_MASK[b])) u_mux (
      .dir(dir_w[b]), .lat(lat_w[b]), .p_en(periph_en[b]),
      .p_oe(periph_oe[b]), .p_out(periph_out[b]), .pin_sync(pin_sync[b]),
      .pad_out(pad_out[b]), .pad_oe(pad_oe[b]), .p_in(periph_in[b])
    );
  end
endmodule

// File: rtl/gpio_shared_port_chk.sv
module gpio_shared_port_chk #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = 8'hBF
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       bus_addr,
  input logic             bus_wen,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] periph_en,
  input logic [WIDTH-1:0] periph_oe,
  input logic [WIDTH-1:0] periph_out,
  input logic [WIDTH-1:0] periph_in,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] lat
);
  logic [WIDTH-1:0] grab;
  assign grab = periph_en & periph_oe & IMPL_MASK;

  assert_periph_takes_pad_R5: assert property (@(posedge clk) disable iff (rst)
    ((grab & ~pad_oe) == '0) && ((grab & (pad_out ^ periph_out)) == '0));

  assert_no_loop_through_R7: assert property (@(posedge clk) disable iff (rst)
    (periph_in & pad_oe & ~grab) == '0);

  assert_missing_bits_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe | pad_out | periph_in | bus_rdata) & ~IMPL_MASK) == '0);

  assert_latch_load_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=>
      (lat == ($past(bus_wdata) & IMPL_MASK)));

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_wen && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=> $stable(lat));
endmodule

bind gpio_shared_port gpio_shared_port_chk #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_en(periph_en),
  .periph_oe(periph_oe), .periph_out(periph_out), .periph_in(periph_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .lat(lat_w)
);

// File: tb/tb_gpio_shared_port.sv
module tb_gpio_shared_port;
  localparam int         W    = 8;
  localparam logic [7:0] MASK = 8'hBF;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   bus_addr = '0;
  logic         bus_wen = 1'b0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic [W-1:0] periph_en = '0, periph_oe = '0, periph_out = '0, periph_in;
  logic [W-1:0] pad_in = '0, pad_out, pad_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_shared_port #(.WIDTH(W), .IMPL_MASK(MASK)) dut (.*);

  // reference model built from the requirements
  logic [W-1:0] m_dir, m_lat, m_s1, m_s2, m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_dir <= MASK; m_lat <= '0; m_s1 <= '0; m_s2 <= '0; m_rd <= '0;
    end else begin
      m_s1 <= pad_in;
      m_s2 <= m_s1;
      case (bus_addr)
        2'd0: m_rd <= m_dir;
        2'd1: m_rd <= m_lat;
        2'd2: m_rd <= m_s2 & MASK;
        default: m_rd <= '0;
      endcase
      if (bus_wen && bus_addr == 2'd0) m_dir <= bus_wdata & MASK;
      if (bus_wen && (bus_addr == 2'd1 || bus_addr == 2'd2)) m_lat <= bus_wdata & MASK;
    end
  end

  function automatic logic [W-1:0] exp_oe();
    logic [W-1:0] own = periph_en & periph_oe;
    return ((own | ~m_dir) & MASK);
  endfunction
  function automatic logic [W-1:0] exp_out();
    logic [W-1:0] own = periph_en & periph_oe;
    return (((own & periph_out) | (~own & m_lat)) & MASK);
  endfunction
  function automatic logic [W-1:0] exp_pin();
    logic [W-1:0] own = periph_en & periph_oe;
    logic [W-1:0] portdrv = ~own & ~m_dir;
    return (m_s2 & ~portdrv & MASK);
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R9 rdata", bus_rdata, m_rd);
    check("R2 pad_oe", pad_oe, exp_oe());
    check("R3 pad_out", pad_out, exp_out());
    check("R7 periph_in", periph_in, exp_pin());
  endtask

  task automatic cyc();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    bus_addr = a; bus_wen = 1'b1; bus_wdata = d;
    cyc();
    bus_wen = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 rdata", bus_rdata, '0);
    check("R1 pad_oe", pad_oe, '0);
    rst = 1'b0;
    bus_addr = 2'd0;
    cyc();
    check("R1 dir reset", bus_rdata, MASK);
    bus_addr = 2'd1;
    cyc();
    check("R1 latch reset", bus_rdata, '0);
    // R2/R3/R8 drive all bits, including the missing one
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF);
    check("R8 pad_oe missing bit", pad_oe, MASK);
    check("R3 pad_out", pad_out, MASK);
    bus_addr = 2'd0;
    cyc();
    check("R8 dir read", bus_rdata, 8'h00);
    // R4 write via pin address lands in latch
    wr(2'd2, 8'h5A);
    bus_addr = 2'd1;
    cyc();
    check("R4 latch via pin addr", bus_rdata, 8'h5A & MASK);
    bus_addr = 2'd0;
    cyc();
    check("R4 dir untouched", bus_rdata, 8'h00);
    // R9 address 3 write ignored and reads zero
    wr(2'd3, 8'hFF);
    cyc();
    check("R9 addr3 read", bus_rdata, '0);
    bus_addr = 2'd1;
    cyc();
    check("R9 addr3 write ignored", bus_rdata, 8'h5A & MASK);
    // R6 enabled peripheral without drive, R5 with drive
    periph_en = 8'hFF; periph_oe = 8'h00; periph_out = 8'hFF;
    cyc();
    check("R6 port keeps pad", pad_out, 8'h5A & MASK);
    periph_oe = 8'h0F;
    cyc();
    check("R5 periph drives", pad_out, (8'h5A & 8'hB0) | 8'h0F);
    periph_en = '0; periph_oe = '0;
    // R7 port drives while pad shows opposite level
    pad_in = 8'hFF;
    repeat (3) cyc();
    check("R7 blanked", periph_in, '0);
    bus_addr = 2'd2;
    cyc();
    check("R4 pin read", bus_rdata, MASK);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      bus_addr  = 2'($urandom_range(0, 3));
      bus_wen   = ($urandom_range(0, 9) < 3);
      bus_wdata = W'($urandom);
      periph_en = W'($urandom);
      periph_oe = W'($urandom);
      periph_out = W'($urandom);
      pad_in    = W'($urandom);
      cyc();
    end
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule